// File: doc/BRIEF.md
# Synthesizer Serial Configuration Port

This block is the three-wire configuration port of a frequency synthesizer. An external controller sends 20-bit words over a serial clock and data pair. A pulse on the latch line then commits the word. The two lowest bits of each word choose which internal register takes it: the reference divider, the swallow and main divider pair, or the operating-mode register. The decoded fields drive the synthesizer's power enable, prescaler choice, charge-pump current code, charge-pump sign bits and charge-pump test mode.

A shared status output is driven through a multiplexer. It can carry the lock indicator, a constant low, the divided reference waveform, the divided LO waveform, or a serial readback of the shift register. The serial port keeps working while the synthesizer is powered down.

All three serial inputs are oversampled by a system clock through synchronizers, so the whole block runs in one clock domain. The lock indicator and the two divided waveforms are taken as already synchronous to that clock. A synchronous active-high reset clears every register. After reset the synthesizer is powered down and the charge pump is in normal mode.

Top module: `pll_cfg_port`

## Requirements
- R1: A bit is taken from `ser_dat` at each rising edge of `ser_clk`. A word is sent with bit 20 first and bit 1 last, so the word is the last 20 bits shifted in before the latch.
- R2: Registers change only on a rising edge of `ser_latch`. Word bits 2:1 choose the target: 00 is the reference register, 01 is the A/B register and 10 is the mode register. Registers that are not chosen keep their values.
- R3: For target 00, `r_div` takes word bits 17:3, with bit 3 as the LSB. Bits 20:18 have no effect.
- R4: For target 01, `a_div` takes word bits 9:3 and `b_div` takes word bits 20:10, each with its lowest bit as the LSB.
- R5: For target 10 the mode fields are taken from these word bits:
  - `pll_en` = bit 3, where 1 means enabled.
  - `presc_sel` = bit 5, where 0 means 32/33 and 1 means 64/65.
  - `cp_cur` = {bit 7, bit 6}, where 00/01/10/11 mean 0.25/0.50/0.75/1.00 mA.
  - `cp_sign` = {bit 9, bit 8}.
  - `ld_sel` = {bit 16, bit 11, bit 10}.
  - `cp_test` = {bit 18, bit 17}, where 00 is normal, 01 is constant source, 10 is constant sink and 11 is high impedance.
- R6: In a mode word, the filler bits 4, 12 to 15, 19 and 20 have no effect on any output.
- R7: A word whose bits 2:1 are 11 changes no register.
- R8: `ld_out` is chosen by `ld_sel`, registered one clock:
  - 00x gives `lock_in`.
  - 01x gives 0.
  - 10x gives the shift register MSB.
  - 110 gives `ref_wave`.
  - 111 gives `lo_wave`.
- R9: In readback mode, `ld_out` shows bit 20 of the word just shifted in. Each further `ser_clk` rise moves it to the next lower bit of that word.
- R10: While `rst` is high, every register clears to zero and `ld_out` is 0. This leaves `pll_en` at 0 and `cp_test` at 00.
- R11: Words are still accepted and loaded while `pll_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data |
| ser_latch | input | 1 | Latch enable; its rising edge commits the word |
| lock_in | input | 1 | Lock indicator from the phase detector |
| ref_wave | input | 1 | Divided reference waveform |
| lo_wave | input | 1 | Divided LO waveform |
| ld_out | output | 1 | Multiplexed status output |
| pll_en | output | 1 | Synthesizer power enable |
| presc_sel | output | 1 | Prescaler choice |
| cp_cur | output | 2 | Charge-pump current code |
| cp_sign | output | 2 | Charge-pump sign bits |
| cp_test | output | 2 | Charge-pump test mode |
| ld_sel | output | 3 | Status multiplexer select code |
| r_div | output | 15 | Reference divide value |
| a_div | output | 7 | Swallow counter value |
| b_div | output | 11 | Main divider value |

## Verification
The assertions assume that each level on `ser_clk`, `ser_dat` and `ser_latch` is held for more than the synchronizer depth plus one system clock. They also assume that `ser_dat` is steady around each rising edge of `ser_clk`, and that the latch is raised only after the last bit is in. The stimulus holds every serial level for four system clocks, and it changes data only while `ser_clk` is low. `lock_in`, `ref_wave` and `lo_wave` are driven in step with the system clock, so the one-clock register in front of `ld_out` sees settled values.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  localparam int WORD_W = 20;
  localparam int TGT_W  = 2;
  localparam int R_W    = 15;
  localparam int A_W    = 7;
  localparam int B_W    = 11;
  localparam int PAY_LO = TGT_W;            // first payload bit index
  localparam int B_LO   = PAY_LO + A_W;     // main divider starts after swallow

  typedef enum logic [TGT_W-1:0] {
    TGT_REF  = 2'b00,
    TGT_AB   = 2'b01,
    TGT_MODE = 2'b10,
    TGT_NONE = 2'b11
  } tgt_e;

  typedef struct packed {
    logic       en;
    logic       presc;
    logic [1:0] cur;
    logic [1:0] sign;
    logic [2:0] ldsel;
    logic [1:0] test;
  } mode_t;
endpackage

// File: rtl/pll_cfg_sync.sv
module pll_cfg_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] level,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-1:0], async_in[i]};
    end
    assign level[i] = chain[STAGES-1];
    assign rise[i]  = chain[STAGES-1] & ~chain[STAGES];
  end
endmodule

// File: rtl/pll_cfg_shift.sv
module pll_cfg_shift
  import pll_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              din,
  output logic [WORD_W-1:0] sr
);
  always_ff @(posedge clk) begin
    if (rst)           sr <= '0;
    else if (shift_en) sr <= {sr[WORD_W-2:0], din};
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(sr));
  assert_advance_R1: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> sr[WORD_W-1:1] == $past(sr[WORD_W-2:0]));
endmodule

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
  import pll_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic [R_W-1:0]    r_div,
  output logic [A_W-1:0]    a_div,
  output logic [B_W-1:0]    b_div,
  output mode_t             mode
);
  tgt_e tgt;
  assign tgt = tgt_e'(word[TGT_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      r_div <= '0;
      a_div <= '0;
      b_div <= '0;
      mode  <= '0;
    end else if (load) begin
      case (tgt)
        TGT_REF: r_div <= word[PAY_LO +: R_W];
        TGT_AB: begin
          a_div <= word[PAY_LO +: A_W];
          b_div <= word[B_LO +: B_W];
        end
        TGT_MODE: begin
          mode.en    <= word[2];
          mode.presc <= word[4];
          mode.cur   <= word[6:5];
          mode.sign  <= word[8:7];
          mode.ldsel <= {word[15], word[10], word[9]};
          mode.test  <= word[17:16];
        end
        default: ;
      endcase
    end
  end

  assert_latch_only_R2: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable({r_div, a_div, b_div, mode}));
  assert_ref_isolated_R2: assert property (@(posedge clk) disable iff (rst)
    (load && word[1:0] == 2'b00) |=> $stable({a_div, b_div, mode}));
  assert_discard_R7: assert property (@(posedge clk) disable iff (rst)
    (load && word[1:0] == 2'b11) |=> $stable({r_div, a_div, b_div, mode}));
endmodule

// File: rtl/pll_cfg_ldmux.sv
module pll_cfg_ldmux (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  input  logic       lock_in,
  input  logic       ref_wave,
  input  logic       lo_wave,
  input  logic       rb_bit,
  output logic       ld_out
);
  logic nxt;
  always_comb begin
    casez (sel)
      3'b00?:  nxt = lock_in;
      3'b01?:  nxt = 1'b0;
      3'b10?:  nxt = rb_bit;
      3'b110:  nxt = ref_wave;
      default: nxt = lo_wave;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ld_out <= 1'b0;
    else     ld_out <= nxt;
  end

  assert_low_R8: assert property (@(posedge clk) disable iff (rst)
    (sel[2:1] == 2'b01) |=> !ld_out);
  assert_lock_R8: assert property (@(posedge clk) disable iff (rst)
    (sel[2:1] == 2'b00) |=> ld_out == $past(lock_in));
endmodule

// File: rtl/pll_cfg_port.sv
module pll_cfg_port
  import pll_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ser_clk,
  input  logic           ser_dat,
  input  logic           ser_latch,
  input  logic           lock_in,
  input  logic           ref_wave,
  input  logic           lo_wave,
  output logic           ld_out,
  output logic           pll_en,
  output logic           presc_sel,
  output logic [1:0]     cp_cur,
  output logic [1:0]     cp_sign,
  output logic [1:0]     cp_test,
  output logic [2:0]     ld_sel,
  output logic [R_W-1:0] r_div,
  output logic [A_W-1:0] a_div,
  output logic [B_W-1:0] b_div
);
  localparam int IDX_CLK = 0;
  localparam int IDX_DAT = 1;
  localparam int IDX_LAT = 2;

  logic [2:0] s_level, s_rise;
  logic [WORD_W-1:0] sr;
  mode_t mode;
  logic sync_unused;

  pll_cfg_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .async_in({ser_latch, ser_dat, ser_clk}),
    .level(s_level), .rise(s_rise)
  );
  assign sync_unused = ^{s_level[IDX_CLK], s_level[IDX_LAT], s_rise[IDX_DAT]};

  pll_cfg_shift u_shift (
    .clk(clk), .rst(rst),
    .shift_en(s_rise[IDX_CLK]), .din(s_level[IDX_DAT]), .sr(sr)
  );

  pll_cfg_regs u_regs (
    .clk(clk), .rst(rst), .load(s_rise[IDX_LAT]), .word(sr),
    .r_div(r_div), .a_div(a_div), .b_div(b_div), .mode(mode)
  );

  pll_cfg_ldmux u_mux (
    .clk(clk), .rst(rst), .sel(mode.ldsel),
    .lock_in(lock_in), .ref_wave(ref_wave), .lo_wave(lo_wave),
    .rb_bit(sr[WORD_W-1]), .ld_out(ld_out)
  );

  assign pll_en    = mode.en;
  assign presc_sel = mode.presc;
  assign cp_cur    = mode.cur;
  assign cp_sign   = mode.sign;
  assign cp_test   = mode.test;
  assign ld_sel    = mode.ldsel;
endmodule

// File: tb/pll_cfg_port_test.sv
module pll_cfg_port_test;
  logic clk = 1'b0, rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_latch = 1'b0;
  logic lock_in = 1'b0, ref_wave = 1'b0, lo_wave = 1'b1;
  logic ld_out, pll_en, presc_sel;
  logic [1:0] cp_cur, cp_sign, cp_test;
  logic [2:0] ld_sel;
  logic [14:0] r_div;
  logic [6:0] a_div;
  logic [10:0] b_div;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pll_cfg_port uut (.*);

  typedef struct packed {
    logic [1:0] kind; logic [14:0] r; logic [6:0] a; logic [10:0] b;
    logic en; logic presc; logic [1:0] cur; logic [1:0] sign;
    logic [2:0] ldsel; logic [1:0] test; logic [3:0] junk;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 15'h5A3C, 7'h00, 11'h000, 1'b0, 1'b0, 2'd0, 2'd0, 3'b000, 2'd0, 4'hF},
    '{2'd1, 15'h0000, 7'h7F, 11'h400, 1'b0, 1'b0, 2'd0, 2'd0, 3'b000, 2'd0, 4'h0},
    '{2'd2, 15'h0000, 7'h00, 11'h000, 1'b1, 1'b1, 2'd2, 2'd1, 3'b000, 2'd0, 4'hF},
    '{2'd3, 15'h7FFF, 7'h00, 11'h000, 1'b0, 1'b0, 2'd0, 2'd0, 3'b000, 2'd0, 4'h5},
    '{2'd1, 15'h0000, 7'h00, 11'h7FF, 1'b0, 1'b0, 2'd0, 2'd0, 3'b000, 2'd0, 4'h0},
    '{2'd2, 15'h0000, 7'h00, 11'h000, 1'b0, 1'b0, 2'd3, 2'd2, 3'b010, 2'd1, 4'h0},
    '{2'd0, 15'h0001, 7'h00, 11'h000, 1'b0, 1'b0, 2'd0, 2'd0, 3'b000, 2'd0, 4'h0},
    '{2'd2, 15'h0000, 7'h00, 11'h000, 1'b1, 1'b0, 2'd1, 2'd3, 3'b110, 2'd2, 4'hA},
    '{2'd2, 15'h0000, 7'h00, 11'h000, 1'b0, 1'b1, 2'd0, 2'd0, 3'b111, 2'd3, 4'h5},
    '{2'd2, 15'h0000, 7'h00, 11'h000, 1'b1, 1'b1, 2'd3, 2'd0, 3'b100, 2'd0, 4'h2},
    '{2'd2, 15'h0000, 7'h00, 11'h000, 1'b1, 1'b0, 2'd0, 2'd1, 3'b101, 2'd0, 4'h0},
    '{2'd3, 15'h4000, 7'h00, 11'h000, 1'b0, 1'b0, 2'd0, 2'd0, 3'b000, 2'd0, 4'h0},
    '{2'd2, 15'h0000, 7'h00, 11'h000, 1'b1, 1'b0, 2'd2, 2'd2, 3'b000, 2'd1, 4'h9}
  };

  logic [14:0] e_r; logic [6:0] e_a; logic [10:0] e_b;
  logic e_en, e_presc; logic [1:0] e_cur, e_sign, e_test; logic [2:0] e_ldsel;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b; wait_clk(4);
    ser_clk = 1'b1; wait_clk(4);
    ser_clk = 1'b0; wait_clk(4);
  endtask

  task automatic send_word(input logic [19:0] w);
    for (int i = 19; i >= 0; i--) send_bit(w[i]);
    ser_latch = 1'b1; wait_clk(6);
    ser_latch = 1'b0; wait_clk(6);
    @(negedge clk);
  endtask

  function automatic logic [43:0] outs();
    return {r_div, a_div, b_div, pll_en, presc_sel, cp_cur, cp_sign, ld_sel, cp_test};
  endfunction
  function automatic logic [43:0] exps();
    return {e_r, e_a, e_b, e_en, e_presc, e_cur, e_sign, e_ldsel, e_test};
  endfunction

  function automatic logic [19:0] mode_word(input vec_t v);
    return {v.junk[1:0], v.test, v.ldsel[2], v.junk[3:0], v.ldsel[1], v.ldsel[0],
            v.sign, v.cur, v.presc, v.junk[0], v.en, 2'b10};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [19:0] w;
    logic e_ld;
    string req;
    {e_r, e_a, e_b, e_en, e_presc, e_cur, e_sign, e_ldsel, e_test} = '0;
    wait_clk(5);
    @(negedge clk);
    check(outs() == 44'd0 && ld_out == 1'b0, "R10 reset state", {outs(), ld_out}, 64'd0);
    rst = 1'b0;
    lock_in = 1'b1;
    wait_clk(3); @(negedge clk);
    check(ld_out == 1'b1, "R8 lock pass after reset", ld_out, 1);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = TBL[k];
      case (v.kind)
        2'd0: begin w = {v.junk[2:0], v.r, 2'b00};
                req = e_en ? "R3" : "R11"; e_r = v.r; end
        2'd1: begin w = {v.b, v.a, 2'b01}; req = "R4"; e_a = v.a; e_b = v.b; end
        2'd2: begin w = mode_word(v); req = "R5 R6";
                {e_en, e_presc, e_cur, e_sign, e_ldsel, e_test} =
                  {v.en, v.presc, v.cur, v.sign, v.ldsel, v.test}; end
        default: begin w = {v.r, v.junk[2:0], 2'b11}; req = "R7"; end
      endcase
      send_word(w);
      check(outs() == exps(), req, outs(), exps());
      casez (e_ldsel)
        3'b00?: e_ld = lock_in;
        3'b01?: e_ld = 1'b0;
        3'b10?: e_ld = w[19];
        3'b110: e_ld = ref_wave;
        default: e_ld = lo_wave;
      endcase
      check(ld_out == e_ld, (e_ldsel[2:1] == 2'b10) ? "R9" : "R8", ld_out, e_ld);
    end

    // Readback walk: latch a readback-mode word, then shift without latching (R1, R9, R2)
    begin
      vec_t v;
      v = '{2'd2, 15'h0, 7'h0, 11'h0, 1'b1, 1'b0, 2'd1, 2'd2, 3'b100, 2'd0, 4'b0110};
      w = mode_word(v);
      send_word(w);
      e_en = 1'b1; e_presc = 1'b0; e_cur = 2'd1; e_sign = 2'd2; e_ldsel = 3'b100; e_test = 2'd0;
      check(ld_out == w[19], "R9 first readback bit", ld_out, w[19]);
      for (int j = 1; j <= 3; j++) begin
        send_bit(1'b0);
        @(negedge clk);
        check(ld_out == w[19-j], "R1 R9 readback shift", ld_out, w[19-j]);
      end
      check(outs() == exps(), "R2 no change while shifting", outs(), exps());
    end

    // Reset in mid operation clears everything (R10)
    @(negedge clk); rst = 1'b1;
    wait_clk(2); @(negedge clk);
    check(outs() == 44'd0 && ld_out == 1'b0, "R10 mid-run reset", {outs(), ld_out}, 64'd0);
    rst = 1'b0;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule